// File: doc/BRIEF.md
# Zero-Padded SECDED Memory ECC

This block protects a 32-bit DRAM data path with a single-error-correcting, double-error-detecting code. On writes it produces eight check bits per 32-bit word, so the stored word is 40 bits wide. The check bits come from a code defined over 64 data bits. The upper 32 of those bits are tied to zero inside the block on both the encode and the decode side. On reads it recomputes the check bits from the returned data and compares them with the stored ones. It then corrects a single flipped bit or reports an uncorrectable word.

Protection is controlled by an enable input, which software sets independently of the rest of the memory interface. When protection is off, or when the interface runs in its 16-bit data mode, no check bits are produced and read data passes through untouched. The read result comes out of a register one cycle after the read strobe, together with its error flags and syndrome. A sticky status record keeps the syndrome of the first error seen until it is cleared.

Top module: `ecc32_secded`

## Requirements
- R1: With `ecc_en`=1 and `mode16`=0, `wr_check` is the XOR of the parity-check columns of every set bit of the 64-bit word {32'b0, `wr_data`}. The column of data bit i is the i-th 8-bit value in a list of all 8-bit values with exactly three ones, in ascending numeric order, followed by all values with exactly five ones, in ascending order.
- R2: A read whose `rd_check` equals the encoding of `rd_data` yields `rd_data_out`=`rd_data`, both flags low and `syndrome_out`=0.
- R3: If the syndrome (`rd_check` XOR the encoding of `rd_data`) equals the column of data bit i with i<32, that bit is inverted in `rd_data_out`, and `err_single` is high for that one output cycle with `syndrome_out` equal to the syndrome.
- R4: A syndrome with a single one (a flipped check bit) raises `err_single` and leaves `rd_data_out` equal to `rd_data`.
- R5: A nonzero syndrome of even weight raises `err_multi`, keeps `err_single` low and passes `rd_data` through uncorrected.
- R6: A syndrome equal to the column of a padded data bit (i from 32 to 63), or of weight seven, is reported through `err_multi` and not corrected.
- R7: With `ecc_en`=0, `wr_check` is zero, reads pass through unchanged, both flags stay low and `syndrome_out` is zero.
- R8: With `mode16`=1, protection is inactive whatever `ecc_en` holds, with the same outputs as in R7.
- R9: `rd_valid_out` follows `rd_valid_in` one clock later. The flags are high only in a cycle where `rd_valid_out` is high, and each erroneous read raises them for exactly one cycle.
- R10: The first erroneous read with status empty sets `stat_valid`, stores its syndrome in `stat_syndrome` and stores its kind in `stat_multi` (1 = uncorrectable). Later errors do not change the record. `clr_status` empties the record and wins over a capture in the same cycle.
- R11: During and after reset, before any read, `rd_valid_out`, both flags, `syndrome_out`, `rd_data_out` and the status outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en | input | 1 | Protection enable |
| mode16 | input | 1 | 16-bit interface mode; forces protection off |
| wr_data | input | 32 | Word being written |
| wr_check | output | 8 | Check bits to store with the written word |
| rd_valid_in | input | 1 | Read word present on this cycle |
| rd_data | input | 32 | Data half of the stored word |
| rd_check | input | 8 | Check half of the stored word |
| clr_status | input | 1 | Empties the sticky status record |
| rd_valid_out | output | 1 | Registered read result valid |
| rd_data_out | output | 32 | Corrected read data |
| err_single | output | 1 | Corrected single-bit error |
| err_multi | output | 1 | Uncorrectable error |
| syndrome_out | output | 8 | Syndrome of the registered read |
| stat_valid | output | 1 | Status record holds an error |
| stat_syndrome | output | 8 | Syndrome of the first recorded error |
| stat_multi | output | 1 | First recorded error was uncorrectable |

## Verification
The assertions assume that `ecc_en` and `mode16` are settled in the cycle a read is strobed, and that `rd_data` and `rd_check` carry known values whenever `rd_valid_in` is high. The bench changes the mode inputs only at the falling edge, together with the read word. It drops the strobe on the next falling edge, so every read is one clean single-cycle pulse. Error patterns come from flipping chosen bits of a correctly encoded word, or from adding a chosen column to its check bits, so each syndrome class is reached on purpose.

// File: rtl/ecc32_pkg.sv
package ecc32_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 64;
  localparam int CHK_W  = 8;
  localparam int PAD_W  = CODE_W - DATA_W;

  typedef logic [CODE_W-1:0][CHK_W-1:0] col_tab_t;

  // Odd-weight columns: all weight-3 values ascending, then weight-5 values.
  function automatic col_tab_t build_cols();
    col_tab_t t;
    int n;
    t = '0;
    n = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < (1 << CHK_W); v++) begin
        if ($countones(v[CHK_W-1:0]) == w && n < CODE_W) begin
          t[n] = v[CHK_W-1:0];
          n++;
        end
      end
    end
    return t;
  endfunction

  localparam col_tab_t H_COLS = build_cols();

  function automatic logic [CODE_W-1:0] pad_word(input logic [DATA_W-1:0] d);
    return {{PAD_W{1'b0}}, d};
  endfunction

  function automatic logic [CHK_W-1:0] encode64(input logic [CODE_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (d[i]) c = c ^ H_COLS[i];
    end
    return c;
  endfunction
endpackage

// File: rtl/ecc32_encoder.sv
module ecc32_encoder
  import ecc32_pkg::*;
(
  input  logic              active,
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  always_comb begin
    check = active ? encode64(pad_word(data)) : '0;
  end
endmodule

// File: rtl/ecc32_decoder.sv
module ecc32_decoder
  import ecc32_pkg::*;
(
  input  logic              active,
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  check,
  output logic [CHK_W-1:0]  syndrome,
  output logic [DATA_W-1:0] fixed,
  output logic              single,
  output logic              multi,
  output logic              syn_nonzero
);
  logic [DATA_W-1:0] flip;
  logic              check_hit;
  logic              correctable;

  always_comb begin
    syndrome = active ? (check ^ encode64(pad_word(data))) : '0;
    flip = '0;
    // Only the real (lower) data columns are correctable; padded ones are not.
    for (int i = 0; i < DATA_W; i++) begin
      if (syndrome == H_COLS[i]) flip[i] = 1'b1;
    end
    check_hit   = ($countones(syndrome) == 1);
    correctable = (|flip) | check_hit;
    syn_nonzero = (syndrome != '0);
    single      = syn_nonzero & correctable;
    multi       = syn_nonzero & ~correctable;
    fixed       = data ^ flip;
  end
endmodule

// File: rtl/ecc32_status.sv
module ecc32_status
  import ecc32_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             err_evt,
  input  logic             err_is_multi,
  input  logic [CHK_W-1:0] err_syn,
  output logic             stat_valid,
  output logic [CHK_W-1:0] stat_syndrome,
  output logic             stat_multi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid    <= 1'b0;
      stat_syndrome <= '0;
      stat_multi    <= 1'b0;
    end else if (clr) begin
      stat_valid    <= 1'b0;
      stat_syndrome <= '0;
      stat_multi    <= 1'b0;
    end else if (err_evt && !stat_valid) begin
      stat_valid    <= 1'b1;
      stat_syndrome <= err_syn;
      stat_multi    <= err_is_multi;
    end
  end
endmodule

// File: rtl/ecc32_secded.sv
module ecc32_secded
  import ecc32_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_en,
  input  logic              mode16,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CHK_W-1:0]  wr_check,
  input  logic              rd_valid_in,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_check,
  input  logic              clr_status,
  output logic              rd_valid_out,
  output logic [DATA_W-1:0] rd_data_out,
  output logic              err_single,
  output logic              err_multi,
  output logic [CHK_W-1:0]  syndrome_out,
  output logic              stat_valid,
  output logic [CHK_W-1:0]  stat_syndrome,
  output logic              stat_multi
);
  logic              prot_active;
  logic [CHK_W-1:0]  dec_syn;
  logic [DATA_W-1:0] dec_fixed;
  logic              dec_single;
  logic              dec_multi;
  logic              dec_syn_nonzero;
  logic              read_err_evt;

  assign prot_active  = ecc_en & ~mode16;
  assign read_err_evt = rd_valid_in & (dec_single | dec_multi);

  ecc32_encoder u_enc (
    .active (prot_active),
    .data   (wr_data),
    .check  (wr_check)
  );

  ecc32_decoder u_dec (
    .active      (prot_active),
    .data        (rd_data),
    .check       (rd_check),
    .syndrome    (dec_syn),
    .fixed       (dec_fixed),
    .single      (dec_single),
    .multi       (dec_multi),
    .syn_nonzero (dec_syn_nonzero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_out <= 1'b0;
      rd_data_out  <= '0;
      err_single   <= 1'b0;
      err_multi    <= 1'b0;
      syndrome_out <= '0;
    end else begin
      rd_valid_out <= rd_valid_in;
      err_single   <= rd_valid_in & dec_single;
      err_multi    <= rd_valid_in & dec_multi;
      if (rd_valid_in) begin
        rd_data_out  <= dec_fixed;
        syndrome_out <= dec_syn;
      end
    end
  end

  ecc32_status u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr_status),
    .err_evt       (read_err_evt),
    .err_is_multi  (dec_multi),
    .err_syn       (dec_syn),
    .stat_valid    (stat_valid),
    .stat_syndrome (stat_syndrome),
    .stat_multi    (stat_multi)
  );
endmodule

// File: rtl/ecc32_checker.sv
module ecc32_checker
  import ecc32_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ecc_en,
  input logic              mode16,
  input logic [CHK_W-1:0]  wr_check,
  input logic              rd_valid_in,
  input logic [DATA_W-1:0] rd_data,
  input logic              clr_status,
  input logic              rd_valid_out,
  input logic [DATA_W-1:0] rd_data_out,
  input logic              err_single,
  input logic              err_multi,
  input logic [CHK_W-1:0]  syndrome_out,
  input logic              stat_valid,
  input logic [CHK_W-1:0]  stat_syndrome,
  input logic              dec_syn_nonzero
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_single && err_multi)); // R5
  AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (err_single || err_multi) |-> rd_valid_out); // R9
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_in |=> rd_valid_out); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_in |=> !rd_valid_out); // R9
  AST_OFF_WR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_en || mode16) |-> wr_check == '0); // R7
  AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_in && (!ecc_en || mode16)) |=>
      (rd_data_out == $past(rd_data) && !err_single && !err_multi && syndrome_out == '0)); // R8
  AST_SINGLE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    err_single |-> ($countones(syndrome_out) == 1 || $countones(syndrome_out) == 3)); // R3
  AST_NONZERO_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_in && dec_syn_nonzero) |=> (err_single || err_multi)); // R2
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !clr_status) |=> (stat_valid && $stable(stat_syndrome))); // R10
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> !stat_valid); // R10
endmodule

bind ecc32_secded ecc32_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ecc_en          (ecc_en),
  .mode16          (mode16),
  .wr_check        (wr_check),
  .rd_valid_in     (rd_valid_in),
  .rd_data         (rd_data),
  .clr_status      (clr_status),
  .rd_valid_out    (rd_valid_out),
  .rd_data_out     (rd_data_out),
  .err_single      (err_single),
  .err_multi       (err_multi),
  .syndrome_out    (syndrome_out),
  .stat_valid      (stat_valid),
  .stat_syndrome   (stat_syndrome),
  .dec_syn_nonzero (dec_syn_nonzero)
);

// File: tb/ecc32_secded_tb.sv
module ecc32_secded_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_en = 1'b0;
  logic        mode16 = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  wr_check;
  logic        rd_valid_in = 1'b0;
  logic [31:0] rd_data = '0;
  logic [7:0]  rd_check = '0;
  logic        clr_status = 1'b0;
  logic        rd_valid_out;
  logic [31:0] rd_data_out;
  logic        err_single;
  logic        err_multi;
  logic [7:0]  syndrome_out;
  logic        stat_valid;
  logic [7:0]  stat_syndrome;
  logic        stat_multi;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ecc32_secded u_dut (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .mode16(mode16),
    .wr_data(wr_data), .wr_check(wr_check), .rd_valid_in(rd_valid_in),
    .rd_data(rd_data), .rd_check(rd_check), .clr_status(clr_status),
    .rd_valid_out(rd_valid_out), .rd_data_out(rd_data_out),
    .err_single(err_single), .err_multi(err_multi), .syndrome_out(syndrome_out),
    .stat_valid(stat_valid), .stat_syndrome(stat_syndrome), .stat_multi(stat_multi)
  );

  // Bench's own column list: walk values, count ones by shifting.
  function automatic int ones8(input logic [7:0] v);
    int n = 0;
    logic [7:0] x = v;
    while (x != 0) begin
      n += int'(x[0]);
      x = x >> 1;
    end
    return n;
  endfunction

  function automatic logic [7:0] tb_col(input int idx);
    int k = 0;
    for (int v = 0; v < 256; v++)
      if (ones8(v[7:0]) == 3) begin
        if (k == idx) return v[7:0];
        k++;
      end
    for (int v = 0; v < 256; v++)
      if (ones8(v[7:0]) == 5) begin
        if (k == idx) return v[7:0];
        k++;
      end
    return 8'h00;
  endfunction

  function automatic logic [7:0] tb_enc(input logic [31:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 32; i++)
      if (d[i]) c ^= tb_col(i);
    return c;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] d, input logic [7:0] c,
                         input logic en, input logic m16);
    @(negedge clk);
    ecc_en = en; mode16 = m16; rd_data = d; rd_check = c; rd_valid_in = 1'b1;
    @(negedge clk);
    rd_valid_in = 1'b0;
  endtask

  // {data, check-flip, data-flip}
  localparam logic [71:0] VEC [10] = '{
    {32'h0000_0000, 8'h00, 32'h0000_0000},
    {32'hFFFF_FFFF, 8'h00, 32'h0000_0000},
    {32'hA5A5_5A5A, 8'h00, 32'h0000_0000},
    {32'h1234_5678, 8'h00, 32'h0000_0001},
    {32'hDEAD_BEEF, 8'h00, 32'h8000_0000},
    {32'h0F0F_F0F0, 8'h00, 32'h0002_0000},
    {32'hCAFE_F00D, 8'h01, 32'h0000_0000},
    {32'h1357_9BDF, 8'h80, 32'h0000_0000},
    {32'h8765_4321, 8'h00, 32'h0000_0208},
    {32'h5555_AAAA, 8'h04, 32'h0010_0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] syn_exp;
    logic [7:0] stored;
    logic [7:0] first_syn;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "valid", {63'b0, rd_valid_out}, 64'd0);
    chk("R11", "flags", {62'b0, err_single, err_multi}, 64'd0);
    chk("R11", "syndrome/data", {24'b0, syndrome_out, rd_data_out}, 64'd0);
    chk("R11", "status", {55'b0, stat_valid, stat_syndrome}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "after release", {54'b0, stat_valid, stat_multi, rd_valid_out, err_single, err_multi, syndrome_out[2:0]}, 64'd0);

    // Table walk: R1 write path, R2..R5 read classes
    for (int k = 0; k < 10; k++) begin
      logic [31:0] d, dflip;
      logic [7:0]  cflip, stored_chk;
      int nerr;
      string rq;
      d     = VEC[k][71:40];
      cflip = VEC[k][39:32];
      dflip = VEC[k][31:0];
      @(negedge clk);
      ecc_en = 1'b1; mode16 = 1'b0; wr_data = d;
      #1;
      chk("R1", "wr_check", {56'b0, wr_check}, {56'b0, tb_enc(d)});
      stored_chk = tb_enc(d) ^ cflip;
      nerr = $countones(dflip) + $countones(cflip);
      do_read(d ^ dflip, stored_chk, 1'b1, 1'b0);
      syn_exp = tb_enc(d ^ dflip) ^ stored_chk;
      rq = (nerr == 0) ? "R2" : (nerr == 2) ? "R5" : (cflip != 0) ? "R4" : "R3";
      chk(rq, "valid", {63'b0, rd_valid_out}, 64'd1);
      chk(rq, "syndrome", {56'b0, syndrome_out}, {56'b0, syn_exp});
      chk(rq, "data", {32'b0, rd_data_out}, {32'b0, (nerr == 2) ? (d ^ dflip) : d});
      chk(rq, "single", {63'b0, err_single}, {63'b0, nerr == 1});
      chk(rq, "multi", {63'b0, err_multi}, {63'b0, nerr == 2});
      if (nerr == 1 && cflip == 0) begin
        for (int b = 0; b < 32; b++)
          if (dflip[b]) chk("R3", "column", {56'b0, syndrome_out}, {56'b0, tb_col(b)});
      end
      @(negedge clk);
      chk("R9", "flags one cycle", {61'b0, rd_valid_out, err_single, err_multi}, 64'd0);
    end

    // R6 padded column and weight seven
    stored = tb_enc(32'h0BAD_CAFE) ^ tb_col(40);
    do_read(32'h0BAD_CAFE, stored, 1'b1, 1'b0);
    chk("R6", "padded column multi", {62'b0, err_single, err_multi}, 64'd1);
    chk("R6", "padded column data", {32'b0, rd_data_out}, {32'b0, 32'h0BAD_CAFE});
    stored = tb_enc(32'h0BAD_CAFE) ^ tb_col(63);
    do_read(32'h0BAD_CAFE, stored, 1'b1, 1'b0);
    chk("R6", "last column multi", {62'b0, err_single, err_multi}, 64'd1);
    stored = tb_enc(32'h0000_0011) ^ 8'h7F;
    do_read(32'h0000_0011, stored, 1'b1, 1'b0);
    chk("R6", "weight seven multi", {62'b0, err_single, err_multi}, 64'd1);
    chk("R6", "weight seven syndrome", {56'b0, syndrome_out}, 64'h7F);

    // R7 disabled
    @(negedge clk);
    ecc_en = 1'b0; mode16 = 1'b0; wr_data = 32'hFFFF_0000;
    #1;
    chk("R7", "wr_check zero", {56'b0, wr_check}, 64'd0);
    do_read(32'h1111_2222, 8'h5A, 1'b0, 1'b0);
    chk("R7", "passthru data", {32'b0, rd_data_out}, {32'b0, 32'h1111_2222});
    chk("R7", "flags/syndrome", {54'b0, err_single, err_multi, syndrome_out}, 64'd0);

    // R8 16-bit mode overrides enable
    @(negedge clk);
    ecc_en = 1'b1; mode16 = 1'b1; wr_data = 32'h0000_ABCD;
    #1;
    chk("R8", "wr_check zero", {56'b0, wr_check}, 64'd0);
    do_read(32'h0000_ABCD, tb_enc(32'h0000_ABCD) ^ 8'h03, 1'b1, 1'b1);
    chk("R8", "passthru data", {32'b0, rd_data_out}, {32'b0, 32'h0000_ABCD});
    chk("R8", "flags/syndrome", {54'b0, err_single, err_multi, syndrome_out}, 64'd0);

    // R10 sticky status
    @(negedge clk);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    chk("R10", "cleared", {55'b0, stat_valid, stat_syndrome}, 64'd0);
    do_read(32'h2468_ACE0 ^ 32'h0000_0004, tb_enc(32'h2468_ACE0), 1'b1, 1'b0);
    first_syn = tb_col(2);
    chk("R10", "first capture", {54'b0, stat_valid, stat_multi, stat_syndrome}, {54'b0, 2'b10, first_syn});
    do_read(32'h2468_ACE0 ^ 32'h0000_0030, tb_enc(32'h2468_ACE0), 1'b1, 1'b0);
    chk("R10", "kept first", {54'b0, stat_valid, stat_multi, stat_syndrome}, {54'b0, 2'b10, first_syn});
    @(negedge clk);
    clr_status = 1'b1;
    ecc_en = 1'b1; mode16 = 1'b0;
    rd_data = 32'h2468_ACE0 ^ 32'h0000_0300; rd_check = tb_enc(32'h2468_ACE0); rd_valid_in = 1'b1;
    @(negedge clk);
    clr_status = 1'b0; rd_valid_in = 1'b0;
    chk("R10", "clear wins", {63'b0, stat_valid}, 64'd0);
    chk("R5", "double flagged during clear", {62'b0, err_single, err_multi}, 64'd1);
    do_read(32'h2468_ACE0 ^ 32'h0000_0300, tb_enc(32'h2468_ACE0), 1'b1, 1'b0);
    chk("R10", "multi capture", {54'b0, stat_valid, stat_multi, stat_syndrome},
        {54'b0, 2'b11, tb_col(8) ^ tb_col(9)});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule